// File: doc/BRIEF.md
# SDRAM Refresh Request Controller

This block decides when a synchronous DRAM behind an external bus controller needs refreshing, and it asks the bus sequencer for each refresh. A free-running prescaler supplies ticks at one of seven clock divisions. An up-counting refresh timer advances on those ticks and is compared against a programmable interval. Each compare match clears the timer and raises a request for an auto-refresh command. The request stays up until the sequencer grants it. From the grant until the sequencer reports completion, a blocking output stalls all accesses to non-SDRAM external areas. A second match that arrives before the first request is served is held in a one-deep pending slot and is not lost.

When the system asks to go into standby, the block lets any running refresh finish and withdraws any request that has not been granted. It then asks the sequencer to put the SDRAM into self-refresh, and acknowledges standby only after the sequencer confirms entry. On wake it requests self-refresh exit. Once the sequencer confirms exit, the refresh timer restarts from zero. Software programs three registers through a simple write port. Refresh runs only while the bus configuration reports that some area is SDRAM space.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: The prescaler ticks once every 2, 8, 32, 128, 512, 2048 or 4096 clocks for clock-select values 1 to 7. The timer advances by one on each tick. With clock-select 0 the timer holds its value. The timer value is visible on `tmr_count`.
- R2: A compare match happens on a tick where the timer equals the interval register. On that tick the timer clears to zero. Successive requests rise exactly (interval+1)×divide clocks apart.
- R3: A match raises a refresh request only while the enable bit (control bit 0) is 1. Clearing the bit withdraws any request or pending match that has not been granted.
- R4: A match raises a refresh request only while `sdram_space_en` is 1. When the input is 0, `rfsh_req` is 0 from the next cycle on.
- R5: `rfsh_req` stays high until a cycle with `rfsh_gnt` high, then falls in the next cycle. `bus_block` is high from the cycle after the grant through the cycle that samples `rfsh_done`, and is low again in the cycle after it.
- R6: A match that arrives while a request is outstanding or a refresh is running sets a one-deep pending slot. When the running refresh completes, the slot raises `rfsh_req` in the cycle after `rfsh_done`. Further matches beyond one are dropped.
- R7: On `stby_req`, no new requests are raised and `sr_enter_req` stays low while `bus_block` is high. After the refresh completes, `sr_enter_req` is held until `sr_enter_ack`, and `stby_ack` rises in the cycle after the acknowledge.
- R8: While in standby the timer is halted. When `stby_req` falls, `sr_exit_req` is held until `sr_exit_ack`. The timer then restarts from zero.
- R9: After reset, all registers are zero, no requests are raised, `bus_block` and `stby_ack` are low, and the timer reads 0.
- R10: Register writes take effect in the next cycle: address 0 is the control register {clock-select in bits 3:1, enable in bit 0}, address 1 loads the timer, and address 2 loads the interval. A timer write has priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 control, 1 timer, 2 interval) |
| cfg_wdata | input | 8 | Register write data |
| sdram_space_en | input | 1 | Some external area is configured as continuous SDRAM |
| stby_req | input | 1 | System requests standby (level) |
| stby_ack | output | 1 | Standby reached; SDRAM is safe |
| rfsh_req | output | 1 | Auto-refresh request to the bus sequencer |
| rfsh_gnt | input | 1 | Sequencer accepts the refresh request |
| rfsh_done | input | 1 | Sequencer finished the refresh command |
| bus_block | output | 1 | Stall accesses to non-SDRAM external areas |
| sr_enter_req | output | 1 | Request self-refresh entry |
| sr_enter_ack | input | 1 | Self-refresh entry confirmed |
| sr_exit_req | output | 1 | Request self-refresh exit |
| sr_exit_ack | input | 1 | Self-refresh exit confirmed |
| tmr_count | output | 8 | Current refresh timer value |

## Verification
The assertions assume that the sequencer asserts `rfsh_done` only while a granted refresh is running and `rfsh_gnt` only against a live request. They also assume that the self-refresh acknowledges come only while the matching request is high. The bench's sequencer model, both automatic and hand-driven, acts only after it has observed the request or the blocking output at a falling edge, and it drops every acknowledge after one cycle. Configuration is always changed with the clock-select at 0 before a new divide is chosen, so no measurement spans a half-programmed interval.

// File: rtl/srf_pkg.sv
package srf_pkg;

  localparam int SEL_W = 3;

  localparam logic [1:0] A_CTRL     = 2'd0;
  localparam logic [1:0] A_TIMER    = 2'd1;
  localparam logic [1:0] A_INTERVAL = 2'd2;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_DRAIN    = 3'd1,
    ST_SR_ENTER = 3'd2,
    ST_SLEEP    = 3'd3,
    ST_SR_EXIT  = 3'd4
  } stby_state_e;

  // log2 of the prescale ratio for each clock-select code; 0 = stopped
  function automatic int unsigned div_log2(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    return 1;
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 7;
      3'd5:    return 9;
      3'd6:    return 11;
      3'd7:    return 12;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/srf_prescaler.sv
module srf_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [srf_pkg::SEL_W-1:0] sel,
  output logic                     tick
);
  import srf_pkg::*;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + PRE_W'(1);
  end

  always_comb begin
    mask = (PRE_W'(1) << div_log2(sel)) - PRE_W'(1);
    tick = (sel != '0) && ((pre_cnt & mask) == mask);
  end

  // R1: every ratio is at least 2, so ticks are never back to back
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/srf_interval_timer.sv
module srf_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);

  logic step;

  assign step  = run && tick;
  assign match = step && (cnt == interval);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wr)    cnt <= wdata;
    else if (clr)   cnt <= '0;
    else if (match) cnt <= '0;
    else if (step)  cnt <= cnt + CNT_W'(1);
  end

  // R2: a compare match returns the timer to zero
  a_r2_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !wr) |=> (cnt == '0));

  // R1: without a tick, a write or a restart the timer holds
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr && !clr) |=> $stable(cnt));

endmodule

// File: rtl/srf_req_tracker.sv
module srf_req_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic allow,
  input  logic gnt,
  input  logic done,
  output logic req,
  output logic busy,
  output logic pend
);

  logic req_n, busy_n, pend_n;
  logic grant_ev, done_ev;

  assign grant_ev = req && gnt;
  assign done_ev  = busy && done;

  always_comb begin
    req_n  = req;
    busy_n = busy;
    pend_n = pend;
    if (grant_ev) begin
      req_n  = 1'b0;
      busy_n = 1'b1;
    end
    if (done_ev) begin
      busy_n = 1'b0;
      if (pend) begin
        req_n  = 1'b1;
        pend_n = 1'b0;
      end
    end
    if (match && allow) begin
      if (req_n || busy_n) pend_n = 1'b1;
      else                 req_n  = 1'b1;
    end
    if (!allow) begin
      req_n  = 1'b0;
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      busy <= 1'b0;
      pend <= 1'b0;
    end else begin
      req  <= req_n;
      busy <= busy_n;
      pend <= pend_n;
    end
  end

  // R5: blocking starts only from an accepted request
  a_r5_block_from_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req && gnt));

  // R5: an unserved request is held
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt && allow) |=> req);

  // R6: the pending slot only exists behind an occupied request path
  a_r6_pend_behind_req: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (req || busy));

  // R4: a disallowed cycle leaves no request behind
  a_r4_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> !req);

endmodule

// File: rtl/srf_standby_seq.sv
module srf_standby_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_req,
  input  logic busy,
  input  logic req,
  input  logic space_en,
  input  logic sr_enter_ack,
  input  logic sr_exit_ack,
  output logic run,
  output logic restart,
  output logic sr_enter_req,
  output logic sr_exit_req,
  output logic stby_ack
);
  import srf_pkg::*;

  stby_state_e state, state_n;
  logic        sr_used, sr_used_n;

  always_comb begin
    state_n   = state;
    sr_used_n = sr_used;
    case (state)
      ST_RUN:
        if (stby_req) state_n = ST_DRAIN;
      ST_DRAIN:
        if (!busy && !req) begin
          sr_used_n = space_en;
          state_n   = space_en ? ST_SR_ENTER : ST_SLEEP;
        end
      ST_SR_ENTER:
        if (sr_enter_ack) state_n = ST_SLEEP;
      ST_SLEEP:
        if (!stby_req) state_n = sr_used ? ST_SR_EXIT : ST_RUN;
      ST_SR_EXIT:
        if (sr_exit_ack) state_n = ST_RUN;
      default:
        state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      sr_used <= 1'b0;
    end else begin
      state   <= state_n;
      sr_used <= sr_used_n;
    end
  end

  assign run          = (state == ST_RUN);
  assign restart      = (state != ST_RUN) && (state_n == ST_RUN);
  assign sr_enter_req = (state == ST_SR_ENTER);
  assign sr_exit_req  = (state == ST_SR_EXIT);
  assign stby_ack     = (state == ST_SLEEP);

  // R7: self-refresh entry never overlaps a running auto refresh
  a_r7_enter_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_enter_req) |-> !busy);

  // R7: standby is acknowledged only after confirmed entry
  a_r7_ack_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stby_ack) && sr_used) |-> $past(sr_enter_ack));

  // R8: exit request holds until confirmed
  a_r8_exit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_exit_req && !sr_exit_ack) |=> sr_exit_req);

endmodule

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 12,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic              sdram_space_en,
  input  logic              stby_req,
  output logic              stby_ack,
  output logic              rfsh_req,
  input  logic              rfsh_gnt,
  input  logic              rfsh_done,
  output logic              bus_block,
  output logic              sr_enter_req,
  input  logic              sr_enter_ack,
  output logic              sr_exit_req,
  input  logic              sr_exit_ack,
  output logic [CNT_W-1:0]  tmr_count
);
  import srf_pkg::*;

  localparam int SEL_LSB = 1;
  localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

  logic              ctrl_en;
  logic [SEL_W-1:0]  ctrl_sel;
  logic [CNT_W-1:0]  interval;
  logic              wr_ctrl, wr_timer, wr_interval;
  logic              tick, match, run, restart, allow, busy, pend;

  assign wr_ctrl     = cfg_we && (cfg_addr == ADDR_W'(A_CTRL));
  assign wr_timer    = cfg_we && (cfg_addr == ADDR_W'(A_TIMER));
  assign wr_interval = cfg_we && (cfg_addr == ADDR_W'(A_INTERVAL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_sel <= '0;
      interval <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en  <= cfg_wdata[0];
        ctrl_sel <= cfg_wdata[SEL_MSB:SEL_LSB];
      end
      if (wr_interval) interval <= cfg_wdata;
    end
  end

  assign allow = ctrl_en && sdram_space_en && run;

  srf_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (ctrl_sel),
    .tick  (tick)
  );

  srf_interval_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (run),
    .clr      (restart),
    .wr       (wr_timer),
    .wdata    (cfg_wdata),
    .interval (interval),
    .cnt      (tmr_count),
    .match    (match)
  );

  srf_req_tracker u_trk (
    .clk   (clk),
    .rst_n (rst_n),
    .match (match),
    .allow (allow),
    .gnt   (rfsh_gnt),
    .done  (rfsh_done),
    .req   (rfsh_req),
    .busy  (busy),
    .pend  (pend)
  );

  srf_standby_seq u_stb (
    .clk          (clk),
    .rst_n        (rst_n),
    .stby_req     (stby_req),
    .busy         (busy),
    .req          (rfsh_req),
    .space_en     (sdram_space_en),
    .sr_enter_ack (sr_enter_ack),
    .sr_exit_ack  (sr_exit_ack),
    .run          (run),
    .restart      (restart),
    .sr_enter_req (sr_enter_req),
    .sr_exit_req  (sr_exit_req),
    .stby_ack     (stby_ack)
  );

  assign bus_block = busy;

  // R3: with the enable bit clear no request survives
  a_r3_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !rfsh_req);

  // R7: standby acknowledge and self-refresh handshakes are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stby_ack, sr_enter_req, sr_exit_req}));

  // R7: no refresh is requested while the block heads into standby
  a_r7_quiet_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_enter_req || stby_ack) |-> (!rfsh_req && !bus_block));

endmodule

// File: tb/tb_sdram_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_refresh_ctrl;

  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       space_en = 1'b0;
  logic       stby_req = 1'b0;
  logic       man_gnt = 1'b0, man_done = 1'b0;
  logic       auto_on = 1'b0, auto_gnt = 1'b0, auto_done = 1'b0;
  logic       sr_enter_ack = 1'b0, sr_exit_ack = 1'b0;
  logic       stby_ack, rfsh_req, bus_block, sr_enter_req, sr_exit_req;
  logic [7:0] tmr_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rises = 0;
  int t_last = 0, t_prev = 0;
  logic req_q = 1'b0;

  always #2 clk = ~clk;

  sdram_refresh_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sdram_space_en(space_en), .stby_req(stby_req),
    .stby_ack(stby_ack), .rfsh_req(rfsh_req),
    .rfsh_gnt(auto_on ? auto_gnt : man_gnt),
    .rfsh_done(auto_on ? auto_done : man_done),
    .bus_block(bus_block), .sr_enter_req(sr_enter_req),
    .sr_enter_ack(sr_enter_ack), .sr_exit_req(sr_exit_req),
    .sr_exit_ack(sr_exit_ack), .tmr_count(tmr_count)
  );

  // request-rise monitor, reads settled values before the edge updates them
  always @(posedge clk) begin
    cyc <= cyc + 1;
    req_q <= rfsh_req;
    if (rfsh_req && !req_q) begin
      rises  <= rises + 1;
      t_prev <= t_last;
      t_last <= cyc;
    end
  end

  // automatic sequencer: grant on sight, complete one cycle later
  always @(negedge clk) begin
    auto_gnt  <= rfsh_req && !auto_gnt;
    auto_done <= bus_block && !auto_done;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ratio(input int sel);
    return 1 << ((sel == 7) ? 12 : (2 * sel - 1));
  endfunction

  // R1/R2: period between the 2nd and 3rd request rise
  task automatic measure(input int sel, input int ivl);
    int base, limit, waited, exp;
    wr_reg(2'd0, 8'h01);
    wr_reg(2'd2, 8'(ivl));
    wr_reg(2'd1, 8'h00);
    base = rises;
    wr_reg(2'd0, 8'((sel << 1) | 1));
    exp = (ivl + 1) * ratio(sel);
    limit = 4 * exp + 64;
    waited = 0;
    while (rises < base + 3 && waited < limit) begin
      @(negedge clk);
      waited++;
    end
    chk(rises >= base + 3, "R1 requests appear", rises - base, 3);
    chk(t_last - t_prev == exp, $sformatf("R2 period sel=%0d ivl=%0d", sel, ivl),
        t_last - t_prev, exp);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(rfsh_req == 0,  "R9 rfsh_req", rfsh_req, 0);
    chk(bus_block == 0, "R9 bus_block", bus_block, 0);
    chk(stby_ack == 0,  "R9 stby_ack", stby_ack, 0);
    chk(tmr_count == 0, "R9 tmr_count", tmr_count, 0);

    // R10 timer load, R1 stopped with clock-select 0
    wr_reg(2'd1, 8'd77);
    chk(tmr_count == 77, "R10 timer write", tmr_count, 77);
    idle(100);
    chk(tmr_count == 77, "R1 stopped timer holds", tmr_count, 77);

    space_en = 1'b1;
    auto_on  = 1'b1;
    for (int s = 1; s <= 7; s++) measure(s, 2);
    for (int v = 1; v <= 6; v++) measure(1, v);
    measure(2, 0);

    // R3 enable clear: no requests
    wr_reg(2'd0, 8'h02);
    idle(4);
    base = rises;
    idle(200);
    chk(rises == base, "R3 disabled no request", rises - base, 0);

    // R4 no SDRAM space: no requests
    wr_reg(2'd0, 8'h03);
    space_en = 1'b0;
    idle(4);
    base = rises;
    idle(200);
    chk(rises == base && rfsh_req == 0, "R4 no space no request", rises - base, 0);
    space_en = 1'b1;

    // R5/R6 pending saturation with manual sequencer
    auto_on = 1'b0;
    idle(2);
    wr_reg(2'd2, 8'd1);
    wr_reg(2'd1, 8'd0);
    wr_reg(2'd0, 8'h03);
    idle(40);
    wr_reg(2'd0, 8'h01);
    idle(2);
    chk(rfsh_req == 1,  "R5 request held", rfsh_req, 1);
    chk(bus_block == 0, "R5 no block before grant", bus_block, 0);
    man_gnt = 1'b1; @(negedge clk); man_gnt = 1'b0;
    chk(rfsh_req == 0,  "R5 request drops after grant", rfsh_req, 0);
    chk(bus_block == 1, "R5 block after grant", bus_block, 1);
    idle(5);
    chk(bus_block == 1, "R5 block holds until done", bus_block, 1);
    man_done = 1'b1; @(negedge clk); man_done = 1'b0;
    chk(bus_block == 0, "R5 block ends after done", bus_block, 0);
    chk(rfsh_req == 1,  "R6 pending re-raises", rfsh_req, 1);
    man_gnt = 1'b1; @(negedge clk); man_gnt = 1'b0;
    man_done = 1'b1; @(negedge clk); man_done = 1'b0;
    idle(20);
    chk(rfsh_req == 0 && bus_block == 0, "R6 saturates at one", rfsh_req, 0);

    // R7/R8 standby sequence
    wr_reg(2'd2, 8'd3);
    wr_reg(2'd0, 8'h03);
    while (!rfsh_req) @(negedge clk);
    man_gnt = 1'b1; @(negedge clk); man_gnt = 1'b0;
    stby_req = 1'b1;
    idle(10);
    chk(sr_enter_req == 0, "R7 waits for refresh", sr_enter_req, 0);
    chk(stby_ack == 0,     "R7 no early ack", stby_ack, 0);
    chk(rfsh_req == 0,     "R7 no new request", rfsh_req, 0);
    man_done = 1'b1; @(negedge clk); man_done = 1'b0;
    idle(2);
    chk(sr_enter_req == 1, "R7 entry requested", sr_enter_req, 1);
    chk(stby_ack == 0,     "R7 ack waits for entry", stby_ack, 0);
    sr_enter_ack = 1'b1; @(negedge clk); sr_enter_ack = 1'b0;
    chk(stby_ack == 1,     "R7 standby acknowledged", stby_ack, 1);
    chk(sr_enter_req == 0, "R7 entry request drops", sr_enter_req, 0);
    wr_reg(2'd1, 8'd200);
    idle(50);
    chk(tmr_count == 200, "R8 timer halted in standby", tmr_count, 200);
    chk(rfsh_req == 0,    "R8 no request in standby", rfsh_req, 0);
    stby_req = 1'b0;
    @(negedge clk);
    chk(sr_exit_req == 1, "R8 exit requested", sr_exit_req, 1);
    chk(stby_ack == 0,    "R8 ack released", stby_ack, 0);
    idle(5);
    chk(sr_exit_req == 1, "R8 exit request held", sr_exit_req, 1);
    sr_exit_ack = 1'b1; @(negedge clk); sr_exit_ack = 1'b0;
    chk(sr_exit_req == 0, "R8 exit request drops", sr_exit_req, 0);
    chk(tmr_count <= 1,   "R8 timer restarts from zero", tmr_count, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule